// File: doc/BRIEF.md
# SPI Downstream Bit Overrider

This block sits in the host-to-device data path of an SPI pass-through bridge. It can replace chosen bits of the address and of the first payload bits before they reach the downstream device. A 32-bit mask picks which bits are replaced, and a matching value word supplies the replacement bits. The replacement applies only to lane 0. Lanes 3 to 1 always pass through unchanged.

Two descending counters select the mask bit for the current serial bit. The address index starts at the top of the address when the address phase begins. It starts at 31 in wide (4-byte) mode and at 23 in narrow (3-byte) mode. It then falls by one per bit and stays at 0 once it gets there. The payload index starts at 31 when a payload-start pulse arrives, so the override window is at most 32 bits. When the bit at index 0 has been sent, the window closes. Payload override is only meaningful for single-lane outgoing payloads.

All state advances on the rising edge of `clk`, which is the passthrough serial clock. The outgoing lanes are registered on the falling edge of `clk`, which gives the downstream device half a cycle of setup. The lanes carry one bit per clock and cannot be stalled, so there is no valid/ready handshake and no back-pressure on this path.

Top module: `spi_bit_override`

## Requirements
- R1: During the address phase with `addr_ovr_en` high, lane 0 out is `addr_value[i]` when `addr_mask[i]` is 1 and host lane 0 when it is 0. Index `i` is 31 on the first address bit when `addr_wide` is 1, and 23 when it is 0.
- R2: The address index drops by one for each address bit and saturates at 0. Every bit after the one at index 0 uses index 0. The index is reloaded each time `addr_phase` rises.
- R3: With `addr_ovr_en` low, the address phase causes no replacement, and lane 0 carries host lane 0.
- R4: A `pay_start` pulse opens a 32-bit window at index 31, starting with the pulse's own bit. With `pay_ovr_en` high, lane 0 is `pay_data[i]` where `pay_mask[i]` is 1, otherwise host lane 0. After the bit at index 0 the window closes and later bits pass through. A new pulse inside an open window restarts it at 31.
- R5: When the address override and the payload override are both active, the address replacement bit is used.
- R6: Lanes 3 to 1 always equal the host lanes. With no override active, all four lanes equal the host lanes.
- R7: `cs_n` high closes the payload window and clears the address-phase history. While `cs_n` is high nothing is replaced. An address phase after `cs_n` goes low starts again from the top index.
- R8: `dn_d` changes only on a falling edge of `clk`. It holds the value computed from the inputs and state present at that edge.
- R9: An active-low `rst_n` clears `dn_d` to 0 and closes the payload window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Passthrough serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Host chip select, active low |
| host_d | input | 4 | Host data lanes |
| addr_phase | input | 1 | High while address bits are on the lanes |
| addr_wide | input | 1 | 1: 32-bit address, 0: 24-bit address |
| addr_ovr_en | input | 1 | Address override enable for the current command |
| addr_mask | input | 32 | Address bits to replace |
| addr_value | input | 32 | Replacement address bits |
| pay_start | input | 1 | Pulse on the first bit of an outgoing payload |
| pay_ovr_en | input | 1 | Payload override enable for the current command |
| pay_mask | input | 32 | Payload bits to replace |
| pay_data | input | 32 | Replacement payload bits |
| dn_d | output | 4 | Data lanes toward the downstream device |

## Verification
The address override is exercised with a mask that mixes set and clear bits against random host data. This separates value bits from host bits, and running past index 0 exposes any wrap instead of saturation. Wide and narrow modes are both run so that the two start indices are distinguished. Payload runs cover a 38-bit stream to find the window edge, a restart inside an open window, a window overlapping the address phase to test priority, and a chip-select pulse and a reset in the middle of a window. A check after every input change confirms the outputs hold until the falling edge.

// File: rtl/spo_pkg.sv
package spo_pkg;
  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_ADDR = 2'd1,
    SRC_PAY  = 2'd2
  } src_e;
endpackage

// File: rtl/spo_addr_idx.sv
module spo_addr_idx #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned NARROW = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     phase,
  input  logic                     wide,
  output logic [$clog2(WIDTH)-1:0] idx_o
);
  localparam int unsigned IW = $clog2(WIDTH);

  logic          phase_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_eff;
  logic [IW-1:0] top_idx;

  assign top_idx = wide ? IW'(WIDTH - 1) : IW'(NARROW - 1);
  // first address bit uses the top index directly, no lost cycle
  assign idx_eff = (phase && !phase_q) ? top_idx : idx_q;
  assign idx_o   = idx_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else if (cs_n) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase;
      if (phase) begin
        idx_q <= (idx_eff != '0) ? idx_eff - 1'b1 : '0;
      end
    end
  end

  // R2: index steps down by one per address bit
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase && idx_eff != '0) |=> (idx_q == IW'($past(idx_eff) - 1'b1)));

  // R2: index sticks at zero
  p_idx_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase && idx_eff == '0) |=> (idx_q == '0));
endmodule

// File: rtl/spo_pay_win.sv
module spo_pay_win #(
  parameter int unsigned WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     start,
  output logic                     active_o,
  output logic [$clog2(WIDTH)-1:0] idx_o
);
  localparam int unsigned IW = $clog2(WIDTH);

  logic          flag_q;
  logic [IW-1:0] cnt_q;
  logic          start_v;
  logic          act;
  logic [IW-1:0] idx_eff;

  assign start_v  = start & ~cs_n;
  assign idx_eff  = start_v ? IW'(WIDTH - 1) : cnt_q;
  assign act      = (flag_q & ~cs_n) | start_v;
  assign active_o = act;
  assign idx_o    = idx_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cs_n) begin
      flag_q <= 1'b0;
    end else if (act) begin
      if (idx_eff == '0) begin
        flag_q <= 1'b0;
      end else begin
        flag_q <= 1'b1;
        cnt_q  <= idx_eff - 1'b1;
      end
    end
  end

  // R4: window closes after the bit at index zero
  p_win_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && idx_eff == '0 && !cs_n) |=> !flag_q);

  // R4: counter frozen while no window is open
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act) |=> $stable(cnt_q));

  // R7: chip select high ends the window
  p_cs_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !flag_q);
endmodule

// File: rtl/spo_lane_mux.sv
module spo_lane_mux #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] host,
  input  logic             swap,
  input  logic             bit_i,
  output logic [LANES-1:0] out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_sub
      assign out[g] = swap ? bit_i : host[g];
    end else begin : g_thru
      assign out[g] = host[g];
    end
  end
endmodule

// File: rtl/spi_bit_override.sv
module spi_bit_override #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned ADDR_NARROW = 24,
  parameter int unsigned PAY_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [LANES-1:0]  host_d,
  input  logic              addr_phase,
  input  logic              addr_wide,
  input  logic              addr_ovr_en,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              pay_start,
  input  logic              pay_ovr_en,
  input  logic [PAY_W-1:0]  pay_mask,
  input  logic [PAY_W-1:0]  pay_data,
  output logic [LANES-1:0]  dn_d
);
  import spo_pkg::*;

  localparam int unsigned AIW = $clog2(ADDR_W);
  localparam int unsigned PIW = $clog2(PAY_W);

  logic [AIW-1:0]   a_idx;
  logic [PIW-1:0]   p_idx;
  logic             p_act;
  src_e             src;
  logic             repl;
  logic [LANES-1:0] dn_next;

  spo_addr_idx #(.WIDTH(ADDR_W), .NARROW(ADDR_NARROW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .phase (addr_phase),
    .wide  (addr_wide),
    .idx_o (a_idx)
  );

  spo_pay_win #(.WIDTH(PAY_W)) u_pay (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .start    (pay_start),
    .active_o (p_act),
    .idx_o    (p_idx)
  );

  // address override outranks payload override
  always_comb begin
    if (addr_phase && addr_ovr_en && !cs_n) begin
      src = SRC_ADDR;
    end else if (p_act && pay_ovr_en) begin
      src = SRC_PAY;
    end else begin
      src = SRC_HOST;
    end
  end

  always_comb begin
    unique case (src)
      SRC_ADDR: repl = addr_mask[a_idx] ? addr_value[a_idx] : host_d[0];
      SRC_PAY:  repl = pay_mask[p_idx]  ? pay_data[p_idx]   : host_d[0];
      default:  repl = host_d[0];
    endcase
  end

  spo_lane_mux #(.LANES(LANES)) u_mux (
    .host  (host_d),
    .swap  (src != SRC_HOST),
    .bit_i (repl),
    .out   (dn_next)
  );

  // launch on the falling edge for downstream setup margin
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_d <= '0;
    end else begin
      dn_d <= dn_next;
    end
  end

  // R6: upper lanes never altered
  p_upper_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_d[LANES-1:1] == host_d[LANES-1:1]);
endmodule

// File: tb/sim_spi_bit_override.sv
`timescale 1ns/1ps
module sim_spi_bit_override;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic [3:0]  host_d;
  logic        addr_phase, addr_wide, addr_ovr_en;
  logic [31:0] addr_mask, addr_value;
  logic        pay_start, pay_ovr_en;
  logic [31:0] pay_mask, pay_data;
  logic [3:0]  dn_d;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural model state
  int   m_aidx, m_pcnt;
  bit   m_phq, m_flag;
  logic [3:0] prev_exp;

  always #4 clk = ~clk;

  spi_bit_override u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .host_d(host_d),
    .addr_phase(addr_phase), .addr_wide(addr_wide), .addr_ovr_en(addr_ovr_en),
    .addr_mask(addr_mask), .addr_value(addr_value),
    .pay_start(pay_start), .pay_ovr_en(pay_ovr_en),
    .pay_mask(pay_mask), .pay_data(pay_data), .dn_d(dn_d)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic void model_reset();
    m_aidx = 0; m_pcnt = 0; m_phq = 0; m_flag = 0; prev_exp = 4'h0;
  endfunction

  // called at rising edge + 2ns with inputs already applied
  task automatic tick(input string tag);
    int   aeff, peff;
    bit   pst, pwin, a_on, p_on;
    logic r;
    logic [3:0] exp;
    check("R8 hold", dn_d, prev_exp);
    aeff = (addr_phase && !m_phq) ? (addr_wide ? 31 : 23) : m_aidx;
    pst  = pay_start && !cs_n;
    peff = pst ? 31 : m_pcnt;
    pwin = (m_flag && !cs_n) || pst;
    a_on = addr_phase && addr_ovr_en && !cs_n;
    p_on = pwin && pay_ovr_en;
    r = host_d[0];
    if (a_on)      r = addr_mask[aeff] ? addr_value[aeff] : host_d[0];
    else if (p_on) r = pay_mask[peff]  ? pay_data[peff]   : host_d[0];
    exp = {host_d[3:1], r};
    @(negedge clk); #2;
    check(tag, dn_d, exp);
    prev_exp = exp;
    if (cs_n) begin
      m_phq = 0; m_aidx = 0; m_flag = 0;
    end else begin
      m_phq = addr_phase;
      if (addr_phase) m_aidx = (aeff > 0) ? aeff - 1 : 0;
      if (pwin) begin
        if (peff == 0) m_flag = 0;
        else begin m_pcnt = peff - 1; m_flag = 1; end
      end
    end
    @(posedge clk); #2;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      host_d = 4'($urandom);
      tick(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; cs_n = 1; host_d = 4'h9;
    addr_phase = 0; addr_wide = 1; addr_ovr_en = 0;
    addr_mask = 32'hA5C3_0FF1; addr_value = 32'h3C96_E11D;
    pay_start = 0; pay_ovr_en = 0;
    pay_mask = 32'h0F0F_3C3D; pay_data = 32'h55AA_A5C3;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset", dn_d, 4'h0);
    rst_n = 1;

    // idle passthrough
    cs_n = 0;
    run(8, "R6 idle");

    // wide address, runs past index 0
    addr_phase = 1; addr_wide = 1; addr_ovr_en = 1;
    run(32, "R1 wide");
    run(4, "R2 floor");
    addr_phase = 0;
    run(3, "R2 after");

    // narrow address
    addr_phase = 1; addr_wide = 0;
    run(24, "R1 narrow");
    addr_phase = 0;
    run(2, "R2 gap");
    addr_phase = 1;
    run(5, "R2 reload");
    addr_phase = 0;

    // override disabled
    addr_phase = 1; addr_wide = 1; addr_ovr_en = 0;
    run(10, "R3 off");
    addr_phase = 0;
    run(1, "R3 gap");

    // payload window
    pay_ovr_en = 1; pay_start = 1;
    run(1, "R4 start");
    pay_start = 0;
    run(38, "R4 window");

    // restart inside an open window
    pay_start = 1; run(1, "R4 restart");
    pay_start = 0; run(6, "R4 mid");
    pay_start = 1; run(1, "R4 restart2");
    pay_start = 0; run(4, "R4 mid2");

    // priority with both active
    addr_ovr_en = 1; addr_wide = 1;
    pay_start = 1; addr_phase = 1;
    run(1, "R5 both");
    pay_start = 0;
    run(10, "R5 both");
    addr_phase = 0;
    run(6, "R5 payload");

    // chip select closes the window
    cs_n = 1; run(2, "R7 high");
    cs_n = 0; run(6, "R7 closed");
    addr_phase = 1; run(4, "R7 addr");
    cs_n = 1; run(1, "R7 high addr");
    cs_n = 0; run(6, "R7 reload");
    addr_phase = 0;

    // reset inside an open window
    pay_start = 1; run(1, "R9 pre");
    pay_start = 0; run(3, "R9 pre");
    rst_n = 0; #1;
    check("R9 async", dn_d, 4'h0);
    @(posedge clk); #1;
    rst_n = 1;
    model_reset();
    run(6, "R9 after");

    summary();
  end
endmodule